// File: doc/BRIEF.md
# DMA Channel Register and Interrupt Block

This block is the host-visible register file of a multi-channel DMA controller. The channel count is a parameter, with 2 and 8 as the intended values. It holds a global configuration word and a sync word. Each channel has five words: source address, destination address, link pointer, control and configuration. All of them are presented on flat output buses, so the transfer engine can read them without going through the host port. The engine reports completed and failed transfers with one-cycle set pulses, one per channel.

The block keeps raw terminal-count and error flags per channel. The masks for these flags are not separate registers: each channel's configuration word provides them. Software sees raw and masked views of the flags and clears them by writing ones to two clear addresses. A single interrupt line is high while any masked flag is set.

The host port is a simple request/acknowledge port. A small controller moves between two states. In `ST_IDLE`, a request is accepted and the transition *accept* leads to `ST_ACK`. `ST_ACK` drives the acknowledge, the read data and the error strobe for one cycle, and then takes the transition *return* back to `ST_IDLE` unconditionally. Any access that does not map to a legal register reads as zero, raises the error strobe and changes nothing.

Top module: `dmareg_top`

## Requirements
- R1: After reset all channel words, the global configuration and sync words and all raw flags are zero, and both `irq` and `host_ack` are low.
- R2: A request seen in `ST_IDLE` is acknowledged in the next cycle, for exactly one cycle. Read data and the error strobe are valid while `host_ack` is high.
- R3: Channel c's word w (w = 0 source, 1 destination, 2 link, 3 control, 4 configuration) sits at byte address 0x100 + 0x20*c + 4*w. It can be written and read back, and its value appears on the matching channel output bus at bits [c*32+31 : c*32].
- R4: A channel access whose index is at or above the channel count, or whose word index is 5 to 7, raises `host_err`, reads zero and modifies nothing.
- R5: The global configuration word at 0x30 and the sync word at 0x34 can be read and written, and they appear on `glb_cfg` and `glb_sync`.
- R6: A pulse on `tc_set[c]` or `err_set[c]` sets raw flag c. Raw terminal-count flags read at 0x14 and raw error flags read at 0x18, with bit c for channel c.
- R7: The terminal-count mask for channel c is bit 15 of its configuration word, and the error mask is bit 14. Masked terminal-count status reads at 0x04, masked error status at 0x0C, and their OR at 0x00.
- R8: Writing to 0x08 clears each raw terminal-count flag whose bit is 1 in the written value. Writing to 0x10 does the same for the raw error flags. Flags whose bit is 0 are unchanged.
- R9: A set pulse in the same cycle as a host clear of the same flag leaves the flag set.
- R10: `irq` is high exactly when the masked terminal-count or masked error status is nonzero. It follows mask changes and clears without extra delay.
- R11: The enabled-channel bitmap at 0x1C holds bit 0 of each channel's configuration word, at bit c for channel c.
- R12: Reads of 0xFE0 + 4*i (i = 0..7) return ID byte i in bits 7:0: 0x80 (8 channels) or 0x81 (otherwise), then 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1. Writes there are errors.
- R13: `be_unsup` is high while bit 1 or bit 2 of the global configuration word is set. Bit 0 is the controller enable.
- R14: Misaligned addresses, unmapped addresses, reads of the write-only clear addresses and writes to read-only status addresses raise `host_err`, read zero and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | 1 for write, 0 for read |
| host_addr | input | 12 | Byte address |
| host_wdata | input | 32 | Write data |
| host_ack | output | 1 | One-cycle acknowledge |
| host_rdata | output | 32 | Read data, valid with ack |
| host_err | output | 1 | Bad-access strobe, valid with ack |
| tc_set | input | NCHAN | Terminal-count set pulses from the engine |
| err_set | input | NCHAN | Error set pulses from the engine |
| ch_src | output | NCHAN*32 | Source address words, all channels |
| ch_dst | output | NCHAN*32 | Destination address words |
| ch_link | output | NCHAN*32 | Link pointer words |
| ch_ctrl | output | NCHAN*32 | Control words |
| ch_cfg | output | NCHAN*32 | Configuration words |
| glb_cfg | output | 32 | Global configuration word |
| glb_sync | output | 32 | Sync word |
| be_unsup | output | 1 | Unsupported big-endian mode requested |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds two copies side by side on the same host bus: one with eight channels and one with two. Every access is seen by both copies. The eight-channel copy exercises the full channel window, the masks and the flag logic across all bit positions. The two-channel copy responds to the same writes with errors for channels 2 to 7, which checks the out-of-range rule. It also brings the alternative first ID byte within reach.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int CH_WORDS = 5;
    localparam int CH_BITS  = CH_WORDS * DATA_W;

    localparam logic [ADDR_W-1:0] ID_BASE = 12'hFE0;

    // global word indices (byte address / 4)
    localparam logic [5:0] GW_STAT     = 6'd0;
    localparam logic [5:0] GW_TC_MSK   = 6'd1;
    localparam logic [5:0] GW_TC_CLR   = 6'd2;
    localparam logic [5:0] GW_ERR_MSK  = 6'd3;
    localparam logic [5:0] GW_ERR_CLR  = 6'd4;
    localparam logic [5:0] GW_TC_RAW   = 6'd5;
    localparam logic [5:0] GW_ERR_RAW  = 6'd6;
    localparam logic [5:0] GW_ENABLED  = 6'd7;
    localparam logic [5:0] GW_CFG      = 6'd12;
    localparam logic [5:0] GW_SYNC     = 6'd13;

    typedef enum logic [0:0] {ST_IDLE, ST_ACK} host_st_e;

    typedef enum logic [1:0] {AK_BAD, AK_CHAN, AK_GLOB, AK_ID} acc_kind_e;

    function automatic logic gw_readable(input logic [5:0] gw);
        return (gw == GW_STAT) || (gw == GW_TC_MSK) || (gw == GW_ERR_MSK) ||
               (gw == GW_TC_RAW) || (gw == GW_ERR_RAW) || (gw == GW_ENABLED) ||
               (gw == GW_CFG) || (gw == GW_SYNC);
    endfunction

    function automatic logic gw_writable(input logic [5:0] gw);
        return (gw == GW_TC_CLR) || (gw == GW_ERR_CLR) ||
               (gw == GW_CFG) || (gw == GW_SYNC);
    endfunction

    function automatic logic [7:0] id_byte(input logic [2:0] idx, input logic wide);
        logic [7:0] b;
        unique case (idx)
            3'd0: b = wide ? 8'h80 : 8'h81;
            3'd1: b = 8'h10;
            3'd2: b = 8'h04;
            3'd3: b = 8'h0A;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/dmareg_decode.sv
module dmareg_decode
    import dmareg_pkg::*;
#(
    parameter int NCHAN = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output acc_kind_e         kind,
    output logic [2:0]        ch_idx,
    output logic [2:0]        ch_word,
    output logic [5:0]        gword,
    output logic [2:0]        id_idx
);

    always_comb begin
        ch_idx  = addr[7:5];
        ch_word = addr[4:2];
        gword   = addr[7:2];
        id_idx  = addr[4:2];
        kind    = AK_BAD;
        if (addr[1:0] == 2'b00) begin
            if (addr[ADDR_W-1:8] == 4'h1) begin
                if ((int'(addr[7:5]) < NCHAN) && (addr[4:2] < 3'(CH_WORDS)))
                    kind = AK_CHAN;
            end else if (addr >= ID_BASE) begin
                if (!we)
                    kind = AK_ID;
            end else if (addr[ADDR_W-1:8] == 4'h0) begin
                if (we ? gw_writable(addr[7:2]) : gw_readable(addr[7:2]))
                    kind = AK_GLOB;
            end
        end
    end

endmodule

// File: rtl/dmareg_chan_bank.sv
module dmareg_chan_bank
    import dmareg_pkg::*;
#(
    parameter int NCHAN = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [2:0]              wr_idx,
    input  logic [2:0]              wr_word,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [2:0]              rd_idx,
    input  logic [2:0]              rd_word,
    output logic [DATA_W-1:0]       rd_data,
    output logic [NCHAN*DATA_W-1:0] src_o,
    output logic [NCHAN*DATA_W-1:0] dst_o,
    output logic [NCHAN*DATA_W-1:0] link_o,
    output logic [NCHAN*DATA_W-1:0] ctrl_o,
    output logic [NCHAN*DATA_W-1:0] cfg_o
);

    logic [NCHAN*CH_BITS-1:0] bank_q;

    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        logic [CH_BITS-1:0] words_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words_q <= '0;
            end else if (wr_en && (wr_idx == 3'(c))) begin
                for (int w = 0; w < CH_WORDS; w++) begin
                    if (wr_word == 3'(w))
                        words_q[w*DATA_W +: DATA_W] <= wdata;
                end
            end
        end

        assign bank_q[c*CH_BITS +: CH_BITS] = words_q;
        assign src_o [c*DATA_W +: DATA_W]   = words_q[0*DATA_W +: DATA_W];
        assign dst_o [c*DATA_W +: DATA_W]   = words_q[1*DATA_W +: DATA_W];
        assign link_o[c*DATA_W +: DATA_W]   = words_q[2*DATA_W +: DATA_W];
        assign ctrl_o[c*DATA_W +: DATA_W]   = words_q[3*DATA_W +: DATA_W];
        assign cfg_o [c*DATA_W +: DATA_W]   = words_q[4*DATA_W +: DATA_W];
    end

    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NCHAN; c++) begin
            for (int w = 0; w < CH_WORDS; w++) begin
                if ((rd_idx == 3'(c)) && (rd_word == 3'(w)))
                    rd_data = bank_q[(c*CH_WORDS + w)*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/dmareg_irq.sv
module dmareg_irq #(
    parameter int NCHAN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCHAN-1:0] tc_set,
    input  logic [NCHAN-1:0] err_set,
    input  logic             tc_clr_we,
    input  logic             err_clr_we,
    input  logic [NCHAN-1:0] clr_bits,
    input  logic [NCHAN-1:0] tc_mask,
    input  logic [NCHAN-1:0] err_mask,
    output logic [NCHAN-1:0] raw_tc,
    output logic [NCHAN-1:0] raw_err,
    output logic [NCHAN-1:0] tc_masked,
    output logic [NCHAN-1:0] err_masked,
    output logic             irq
);

    logic [NCHAN-1:0] tc_clr_v;
    logic [NCHAN-1:0] err_clr_v;

    assign tc_clr_v  = tc_clr_we  ? clr_bits : '0;
    assign err_clr_v = err_clr_we ? clr_bits : '0;

    // a set pulse dominates a clear of the same bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_tc  <= '0;
            raw_err <= '0;
        end else begin
            raw_tc  <= (raw_tc  & ~tc_clr_v)  | tc_set;
            raw_err <= (raw_err & ~err_clr_v) | err_set;
        end
    end

    assign tc_masked  = raw_tc  & tc_mask;
    assign err_masked = raw_err & err_mask;
    assign irq        = |{tc_masked, err_masked};

endmodule

// File: rtl/dmareg_top.sv
module dmareg_top
    import dmareg_pkg::*;
#(
    parameter int NCHAN = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_req,
    input  logic                    host_we,
    input  logic [ADDR_W-1:0]       host_addr,
    input  logic [DATA_W-1:0]       host_wdata,
    output logic                    host_ack,
    output logic [DATA_W-1:0]       host_rdata,
    output logic                    host_err,
    input  logic [NCHAN-1:0]        tc_set,
    input  logic [NCHAN-1:0]        err_set,
    output logic [NCHAN*DATA_W-1:0] ch_src,
    output logic [NCHAN*DATA_W-1:0] ch_dst,
    output logic [NCHAN*DATA_W-1:0] ch_link,
    output logic [NCHAN*DATA_W-1:0] ch_ctrl,
    output logic [NCHAN*DATA_W-1:0] ch_cfg,
    output logic [DATA_W-1:0]       glb_cfg,
    output logic [DATA_W-1:0]       glb_sync,
    output logic                    be_unsup,
    output logic                    irq
);

    localparam int TC_MASK_BIT  = 15;
    localparam int ERR_MASK_BIT = 14;
    localparam int CH_EN_BIT    = 0;
    localparam bit WIDE_ID      = (NCHAN == 8);

    host_st_e  st_q, st_d;
    acc_kind_e kind;
    logic [2:0] ch_idx, ch_word, id_idx;
    logic [5:0] gword;
    logic       accept, wr_ok;
    logic [DATA_W-1:0] bank_rd, rd_val;
    logic [NCHAN-1:0]  tc_mask, err_mask, ch_en;
    logic [NCHAN-1:0]  raw_tc, raw_err, tc_masked, err_masked;

    dmareg_decode #(.NCHAN(NCHAN)) decode_i (
        .addr    (host_addr),
        .we      (host_we),
        .kind    (kind),
        .ch_idx  (ch_idx),
        .ch_word (ch_word),
        .gword   (gword),
        .id_idx  (id_idx)
    );

    assign accept = (st_q == ST_IDLE) && host_req;
    assign wr_ok  = accept && host_we;

    dmareg_chan_bank #(.NCHAN(NCHAN)) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ok && (kind == AK_CHAN)),
        .wr_idx  (ch_idx),
        .wr_word (ch_word),
        .wdata   (host_wdata),
        .rd_idx  (ch_idx),
        .rd_word (ch_word),
        .rd_data (bank_rd),
        .src_o   (ch_src),
        .dst_o   (ch_dst),
        .link_o  (ch_link),
        .ctrl_o  (ch_ctrl),
        .cfg_o   (ch_cfg)
    );

    for (genvar c = 0; c < NCHAN; c++) begin : g_mask
        assign tc_mask[c]  = ch_cfg[c*DATA_W + TC_MASK_BIT];
        assign err_mask[c] = ch_cfg[c*DATA_W + ERR_MASK_BIT];
        assign ch_en[c]    = ch_cfg[c*DATA_W + CH_EN_BIT];
    end

    dmareg_irq #(.NCHAN(NCHAN)) irq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tc_set     (tc_set),
        .err_set    (err_set),
        .tc_clr_we  (wr_ok && (kind == AK_GLOB) && (gword == GW_TC_CLR)),
        .err_clr_we (wr_ok && (kind == AK_GLOB) && (gword == GW_ERR_CLR)),
        .clr_bits   (host_wdata[NCHAN-1:0]),
        .tc_mask    (tc_mask),
        .err_mask   (err_mask),
        .raw_tc     (raw_tc),
        .raw_err    (raw_err),
        .tc_masked  (tc_masked),
        .err_masked (err_masked),
        .irq        (irq)
    );

    // global registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_cfg  <= '0;
            glb_sync <= '0;
        end else if (wr_ok && (kind == AK_GLOB)) begin
            if (gword == GW_CFG)
                glb_cfg <= host_wdata;
            if (gword == GW_SYNC)
                glb_sync <= host_wdata;
        end
    end

    assign be_unsup = glb_cfg[1] | glb_cfg[2];

    // read selection
    always_comb begin
        rd_val = '0;
        unique case (kind)
            AK_CHAN: rd_val = bank_rd;
            AK_ID:   rd_val = DATA_W'(id_byte(id_idx, WIDE_ID));
            AK_GLOB: begin
                case (gword)
                    GW_STAT:    rd_val = DATA_W'(tc_masked | err_masked);
                    GW_TC_MSK:  rd_val = DATA_W'(tc_masked);
                    GW_ERR_MSK: rd_val = DATA_W'(err_masked);
                    GW_TC_RAW:  rd_val = DATA_W'(raw_tc);
                    GW_ERR_RAW: rd_val = DATA_W'(raw_err);
                    GW_ENABLED: rd_val = DATA_W'(ch_en);
                    GW_CFG:     rd_val = glb_cfg;
                    GW_SYNC:    rd_val = glb_sync;
                    default:    rd_val = '0;
                endcase
            end
            default: rd_val = '0;
        endcase
    end

    // host controller: state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (host_req) st_d = ST_ACK;
            ST_ACK:  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // host controller: outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_ack   <= 1'b0;
            host_err   <= 1'b0;
            host_rdata <= '0;
        end else if (accept) begin
            host_ack   <= 1'b1;
            host_err   <= (kind == AK_BAD);
            host_rdata <= host_we ? '0 : rd_val;
        end else begin
            host_ack   <= 1'b0;
            host_err   <= 1'b0;
        end
    end

endmodule

// File: rtl/dmareg_chk.sv
module dmareg_chk
    import dmareg_pkg::*;
#(
    parameter int NCHAN = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    host_req,
    input logic                    host_we,
    input logic                    host_ack,
    input logic                    host_err,
    input logic [DATA_W-1:0]       host_rdata,
    input logic [NCHAN-1:0]        tc_set,
    input logic [NCHAN*DATA_W-1:0] ch_cfg,
    input logic                    irq
);

    logic [NCHAN-1:0] tcm, erm;

    for (genvar c = 0; c < NCHAN; c++) begin : g_m
        assign tcm[c] = ch_cfg[c*DATA_W + 15];
        assign erm[c] = ch_cfg[c*DATA_W + 14];
    end

    p_ack_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> $past(host_req));

    p_ack_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

    p_req_answered_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_ack) |=> host_ack);

    p_err_with_ack_r14: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |-> host_ack);

    p_bad_read_zero_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (host_err && !$past(host_we)) |-> (host_rdata == '0));

    p_set_raises_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(tc_set & tcm)) && !host_req) |=> irq);

    p_no_mask_no_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((tcm == '0) && (erm == '0)) |-> !irq);

endmodule

bind dmareg_top dmareg_chk #(.NCHAN(NCHAN)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_req   (host_req),
    .host_we    (host_we),
    .host_ack   (host_ack),
    .host_err   (host_err),
    .host_rdata (host_rdata),
    .tc_set     (tc_set),
    .ch_cfg     (ch_cfg),
    .irq        (irq)
);

// File: tb/dmareg_top_tb.sv
module dmareg_top_tb_top;

    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, we_s = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [7:0] tc_set8 = '0, err_set8 = '0;
    logic [1:0] tc_set2 = '0, err_set2 = '0;

    logic ack8, err8, be8, irq8, ack2, err2, be2, irq2;
    logic [31:0] rdata8, rdata2, gcfg8, gsync8, gcfg2, gsync2;
    logic [255:0] src8, dst8, lnk8, ctl8, cfg8;
    logic [63:0] src2, dst2, lnk2, ctl2, cfg2;

    logic [31:0] r8, r2;
    logic a8, e8, a2, e2;
    int n_chk = 0, n_err = 0;

    always #(CLK_P/2) clk = ~clk;

    dmareg_top #(.NCHAN(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_req(req), .host_we(we_s),
        .host_addr(addr), .host_wdata(wdata), .host_ack(ack8),
        .host_rdata(rdata8), .host_err(err8), .tc_set(tc_set8),
        .err_set(err_set8), .ch_src(src8), .ch_dst(dst8), .ch_link(lnk8),
        .ch_ctrl(ctl8), .ch_cfg(cfg8), .glb_cfg(gcfg8), .glb_sync(gsync8),
        .be_unsup(be8), .irq(irq8)
    );

    dmareg_top #(.NCHAN(2)) dut2_i (
        .clk(clk), .rst_n(rst_n), .host_req(req), .host_we(we_s),
        .host_addr(addr), .host_wdata(wdata), .host_ack(ack2),
        .host_rdata(rdata2), .host_err(err2), .tc_set(tc_set2),
        .err_set(err_set2), .ch_src(src2), .ch_dst(dst2), .ch_link(lnk2),
        .ch_ctrl(ctl2), .ch_cfg(cfg2), .glb_cfg(gcfg2), .glb_sync(gsync2),
        .be_unsup(be2), .irq(irq2)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we_s = w; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we_s = 1'b0;
        a8 = ack8; r8 = rdata8; e8 = err8;
        a2 = ack2; r2 = rdata2; e2 = err2;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        access(1'b1, a, d);
    endtask

    task automatic rd(input logic [11:0] a);
        access(1'b0, a, 32'h0);
    endtask

    task automatic t_reset();
        chk("R1 irq", {31'b0, irq8}, 0);
        chk("R1 ack", {31'b0, ack8}, 0);
        chk("R1 glb_cfg", gcfg8, 0);
        chk("R1 ch_cfg", {31'b0, |cfg8}, 0);
        chk("R1 ch_src", {31'b0, |src8}, 0);
        rd(12'h014);
        chk("R1 raw tc", r8, 0);
    endtask

    task automatic t_handshake();
        rd(12'h034);
        chk("R2 ack high", {31'b0, a8}, 1);
        chk("R2 err low", {31'b0, e8}, 0);
        @(negedge clk);
        chk("R2 ack single", {31'b0, ack8}, 0);
    endtask

    task automatic t_chan_regs();
        for (int c = 0; c < 8; c++)
            for (int w = 0; w < 5; w++)
                wr(12'(12'h100 + c*32 + w*4), 32'hC0DE0000 | (c << 8) | w);
        for (int c = 0; c < 8; c++) begin
            for (int w = 0; w < 5; w++) begin
                rd(12'(12'h100 + c*32 + w*4));
                chk("R3 readback", r8, 32'hC0DE0000 | (c << 8) | w);
            end
            chk("R3 src port", src8[c*32 +: 32], 32'hC0DE0000 | (c << 8));
            chk("R3 link port", lnk8[c*32 +: 32], 32'hC0DE0002 | (c << 8));
            chk("R3 cfg port", cfg8[c*32 +: 32], 32'hC0DE0004 | (c << 8));
        end
    endtask

    task automatic t_chan_bad();
        wr(12'h150, 32'h1234);
        chk("R4 err 2ch", {31'b0, e2}, 1);
        chk("R4 ok 8ch", {31'b0, e8}, 0);
        rd(12'h150);
        chk("R4 read 2ch zero", r2, 0);
        chk("R4 read 2ch err", {31'b0, e2}, 1);
        chk("R3 read 8ch", r8, 32'h1234);
        wr(12'h114, 32'hFFFF);
        chk("R4 word5 err", {31'b0, e8}, 1);
        rd(12'h114);
        chk("R4 word5 zero", r8, 0);
        rd(12'h110);
        chk("R4 no side effect", r8, 32'hC0DE0004);
    endtask

    task automatic t_global();
        wr(12'h030, 32'h1);
        rd(12'h030);
        chk("R5 cfg read", r8, 32'h1);
        chk("R5 cfg port", gcfg8, 32'h1);
        chk("R13 enable only", {31'b0, be8}, 0);
        wr(12'h034, 32'hA5A55A5A);
        rd(12'h034);
        chk("R5 sync read", r8, 32'hA5A55A5A);
        chk("R5 sync port", gsync8, 32'hA5A55A5A);
        wr(12'h030, 32'h2);
        chk("R13 bit1", {31'b0, be8}, 1);
        wr(12'h030, 32'h4);
        chk("R13 bit2", {31'b0, be8}, 1);
        wr(12'h030, 32'h0);
        chk("R13 cleared", {31'b0, be8}, 0);
    endtask

    task automatic t_enabled();
        for (int c = 0; c < 8; c++)
            wr(12'(12'h110 + c*32), 32'h0);
        wr(12'h130, 32'h1);
        wr(12'h170, 32'h1);
        rd(12'h01C);
        chk("R11 bitmap 8ch", r8, 32'h0A);
        chk("R11 bitmap 2ch", r2, 32'h02);
        wr(12'h130, 32'h0);
        wr(12'h170, 32'h0);
    endtask

    task automatic t_flags();
        wr(12'h110, 32'h8000);
        wr(12'h130, 32'h4000);
        chk("R10 idle irq", {31'b0, irq8}, 0);
        @(negedge clk);
        tc_set8 = 8'h03; err_set8 = 8'h03;
        @(negedge clk);
        tc_set8 = '0; err_set8 = '0;
        chk("R10 irq set", {31'b0, irq8}, 1);
        rd(12'h014); chk("R6 raw tc", r8, 32'h03);
        rd(12'h018); chk("R6 raw err", r8, 32'h03);
        rd(12'h004); chk("R7 masked tc", r8, 32'h01);
        rd(12'h00C); chk("R7 masked err", r8, 32'h02);
        rd(12'h000); chk("R7 combined", r8, 32'h03);
        wr(12'h130, 32'h0);
        rd(12'h00C); chk("R7 err mask off", r8, 32'h00);
        rd(12'h018); chk("R7 raw kept", r8, 32'h03);
        chk("R10 irq from tc", {31'b0, irq8}, 1);
        wr(12'h110, 32'h0);
        chk("R10 irq masked off", {31'b0, irq8}, 0);
        rd(12'h000); chk("R7 combined off", r8, 32'h00);
        wr(12'h110, 32'h8000);
        wr(12'h130, 32'h4000);
        chk("R10 irq restored", {31'b0, irq8}, 1);
    endtask

    task automatic t_clear();
        wr(12'h008, 32'h2);
        rd(12'h014); chk("R8 tc partial", r8, 32'h01);
        wr(12'h008, 32'h1);
        rd(12'h014); chk("R8 tc cleared", r8, 32'h00);
        chk("R10 irq err only", {31'b0, irq8}, 1);
        wr(12'h010, 32'h1);
        rd(12'h018); chk("R8 err partial", r8, 32'h02);
        wr(12'h010, 32'h2);
        rd(12'h018); chk("R8 err cleared", r8, 32'h00);
        chk("R10 irq low", {31'b0, irq8}, 0);
    endtask

    task automatic t_set_wins();
        @(negedge clk);
        tc_set8 = 8'h04;
        @(negedge clk);
        tc_set8 = '0;
        @(negedge clk);
        req = 1'b1; we_s = 1'b1; addr = 12'h008; wdata = 32'h4; tc_set8 = 8'h04;
        @(negedge clk);
        req = 1'b0; we_s = 1'b0; tc_set8 = '0;
        rd(12'h014); chk("R9 set wins", r8, 32'h04);
        wr(12'h008, 32'h4);
        rd(12'h014); chk("R9 later clear", r8, 32'h00);
    endtask

    task automatic t_id();
        logic [7:0] exp_b [8];
        exp_b = '{8'h80, 8'h10, 8'h04, 8'h0A, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int i = 0; i < 8; i++) begin
            rd(12'(12'hFE0 + i*4));
            chk("R12 id 8ch", r8, {24'b0, exp_b[i]});
            if (i == 0) chk("R12 id0 2ch", r2, 32'h81);
            else        chk("R12 id 2ch", r2, {24'b0, exp_b[i]});
        end
        wr(12'hFE0, 32'h0);
        chk("R12 write err", {31'b0, e8}, 1);
    endtask

    task automatic t_unmapped();
        rd(12'h008);
        chk("R14 clr read err", {31'b0, e8}, 1);
        chk("R14 clr read zero", r8, 0);
        rd(12'h200); chk("R14 hole err", {31'b0, e8}, 1);
        rd(12'h020); chk("R14 soft req err", {31'b0, e8}, 1);
        rd(12'h101); chk("R14 misaligned err", {31'b0, e8}, 1);
        chk("R14 misaligned zero", r8, 0);
        wr(12'h014, 32'hFF);
        chk("R14 ro write err", {31'b0, e8}, 1);
        wr(12'h032, 32'hFF);
        chk("R14 misaligned write err", {31'b0, e8}, 1);
        chk("R14 cfg unchanged", gcfg8, 32'h0);
        rd(12'h014); chk("R14 raw unchanged", r8, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_handshake();
        t_chan_regs();
        t_chan_bad();
        t_global();
        t_enabled();
        t_flags();
        t_clear();
        t_set_wins();
        t_id();
        t_unmapped();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule